// File: doc/BRIEF.md
# Triangle Visibility Depth Tester

This block sits after a rasterizer in a deferred-shading renderer. Each incoming pixel carries only its screen position, its depth and the serial number of the triangle it came from. The block compares the depth with a screen-sized depth store. When the pixel wins, it writes the new depth there, and it writes the triangle number into a screen-sized index store of the same shape. Colour is never produced here. A later shading stage rebuilds the image from the index store.

The final pixel of each triangle carries a marker. Once that pixel has been tested, the block reports whether any pixel of the triangle survived. Upstream geometry uses this flag to skip normal transforms and lighting for triangles that are fully hidden. A clear command resets both stores before a new frame. Both stores live outside the block and are reached through a one-cycle-latency read port and a write port.

Top module: `idx_depth_test`

## Requirements
- R1: An accepted pixel at column x and row y reads the depth store at address y*SCR_W + x in its acceptance cycle. The data is expected one cycle later.
- R2: A pixel passes only when its depth is strictly smaller than the stored depth. A pixel with equal or greater depth leaves both stores untouched.
- R3: A passing pixel writes its depth to the depth store and its triangle number to the index store, both at its own address, in the cycle after it is accepted.
- R4: When pixels hit the same address on consecutive cycles, the later pixel is compared with the depth the earlier one just wrote, not with the stale value from the store.
- R5: The pixel marked last ends its triangle. The block then raises vis_valid with vis_flag=1 if at least one pixel of that triangle passed, else 0, and with vis_tri equal to that triangle's number.
- R6: vis_valid, vis_flag and vis_tri hold steady until vis_ready is seen high. pix_ready stays low from acceptance of the last pixel until that handshake.
- R7: A clear_req pulse writes the all-ones depth and index 0 (meaning "no triangle") to every address. pix_ready stays low from the request until the whole sweep is done, and clear_busy is high during the sweep.
- R8: After reset, pix_ready is 1, vis_valid is 0, clear_busy is 0, and neither store is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel may be accepted |
| pix_x | input | XW | Pixel column |
| pix_y | input | YW | Pixel row |
| pix_z | input | ZW | Pixel depth |
| pix_tri | input | TW | Parent triangle number |
| pix_last | input | 1 | Final pixel of the triangle |
| clear_req | input | 1 | Start a frame clear |
| clear_busy | output | 1 | Clear sweep in progress |
| vis_valid | output | 1 | Visibility result available |
| vis_ready | input | 1 | Result consumed |
| vis_flag | output | 1 | 1 = triangle visible |
| vis_tri | output | TW | Triangle the result belongs to |
| zmem_rd_en | output | 1 | Depth read strobe |
| zmem_rd_addr | output | AW | Depth read address |
| zmem_rd_data | input | ZW | Depth read data, one cycle after the strobe |
| zmem_wr_en | output | 1 | Depth write strobe |
| zmem_wr_addr | output | AW | Depth write address |
| zmem_wr_data | output | ZW | Depth write data |
| imem_wr_en | output | 1 | Index write strobe |
| imem_wr_addr | output | AW | Index write address |
| imem_wr_data | output | TW | Index write data |

## Verification
The embedded assertions check the cycle-level rules on every clock:
- the result stays stable while it waits for its handshake;
- the input stays closed while a result is pending or a clear is running;
- every pixel write follows a read of the same address one cycle earlier;
- a result appears only after a last pixel has been tested.

The bench scenarios are the only place where store contents and flags are checked against an independent model. They cover strict-versus-equal comparison, same-address forwarding on back-to-back pixels, visible and fully hidden triangles, and the contents left after a clear.

// File: rtl/idx_depth_test.sv
module idx_depth_test #(
  parameter int SCR_W = 320,
  parameter int SCR_H = 200,
  parameter int ZW    = 16,
  parameter int TW    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               pix_valid,
  output logic                               pix_ready,
  input  logic [$clog2(SCR_W)-1:0]           pix_x,
  input  logic [$clog2(SCR_H)-1:0]           pix_y,
  input  logic [ZW-1:0]                      pix_z,
  input  logic [TW-1:0]                      pix_tri,
  input  logic                               pix_last,
  input  logic                               clear_req,
  output logic                               clear_busy,
  output logic                               vis_valid,
  input  logic                               vis_ready,
  output logic                               vis_flag,
  output logic [TW-1:0]                      vis_tri,
  output logic                               zmem_rd_en,
  output logic [$clog2(SCR_W*SCR_H)-1:0]     zmem_rd_addr,
  input  logic [ZW-1:0]                      zmem_rd_data,
  output logic                               zmem_wr_en,
  output logic [$clog2(SCR_W*SCR_H)-1:0]     zmem_wr_addr,
  output logic [ZW-1:0]                      zmem_wr_data,
  output logic                               imem_wr_en,
  output logic [$clog2(SCR_W*SCR_H)-1:0]     imem_wr_addr,
  output logic [TW-1:0]                      imem_wr_data
);
  localparam int NPIX = SCR_W * SCR_H;
  localparam int AW   = $clog2(NPIX);
  localparam logic [ZW-1:0] ZMAX = {ZW{1'b1}};
  localparam logic [AW-1:0] ALAST = AW'(NPIX - 1);

  logic          s1_v, s1_last;
  logic [AW-1:0] s1_a;
  logic [ZW-1:0] s1_z;
  logic [TW-1:0] s1_t;
  logic          fwd_v;
  logic [AW-1:0] fwd_a;
  logic [ZW-1:0] fwd_z;
  logic          any_pass, wait_ack, clr_pend, clr_busy;
  logic [AW-1:0] clr_a;
  logic [AW-1:0] pix_addr;
  logic [ZW-1:0] cur_z;
  logic          accept, pass;

  assign pix_ready  = !wait_ack && !clr_pend && !clr_busy;
  assign accept     = pix_valid && pix_ready;
  assign pix_addr   = AW'(pix_y) * AW'(SCR_W) + AW'(pix_x);
  assign clear_busy = clr_busy;

  assign zmem_rd_en   = accept;
  assign zmem_rd_addr = pix_addr;

  assign cur_z = (fwd_v && fwd_a == s1_a) ? fwd_z : zmem_rd_data;
  assign pass  = s1_v && (s1_z < cur_z);

  assign zmem_wr_en   = clr_busy || pass;
  assign zmem_wr_addr = clr_busy ? clr_a : s1_a;
  assign zmem_wr_data = clr_busy ? ZMAX : s1_z;
  assign imem_wr_en   = zmem_wr_en;
  assign imem_wr_addr = zmem_wr_addr;
  assign imem_wr_data = clr_busy ? '0 : s1_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_last <= 1'b0; s1_a <= '0; s1_z <= '0; s1_t <= '0;
      fwd_v <= 1'b0; fwd_a <= '0; fwd_z <= '0;
    end else begin
      s1_v    <= accept;
      s1_last <= pix_last;
      s1_a    <= pix_addr;
      s1_z    <= pix_z;
      s1_t    <= pix_tri;
      fwd_v   <= pass;
      fwd_a   <= s1_a;
      fwd_z   <= s1_z;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      any_pass <= 1'b0; wait_ack <= 1'b0;
      vis_valid <= 1'b0; vis_flag <= 1'b0; vis_tri <= '0;
    end else begin
      if (accept && pix_last) wait_ack <= 1'b1;
      if (s1_v && s1_last) begin
        vis_valid <= 1'b1;
        vis_flag  <= any_pass || pass;
        vis_tri   <= s1_t;
        any_pass  <= 1'b0;
      end else if (s1_v) begin
        any_pass <= any_pass || pass;
      end
      if (vis_valid && vis_ready) begin
        vis_valid <= 1'b0;
        wait_ack  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_pend <= 1'b0; clr_busy <= 1'b0; clr_a <= '0;
    end else begin
      if (clear_req) clr_pend <= 1'b1;
      if (clr_pend && !clr_busy && !s1_v) begin
        clr_pend <= clear_req;
        clr_busy <= 1'b1;
        clr_a    <= '0;
      end else if (clr_busy) begin
        clr_a <= clr_a + 1'b1;
        if (clr_a == ALAST) clr_busy <= 1'b0;
      end
    end
  end

  assert_vis_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vis_valid && !vis_ready |=> vis_valid && $stable(vis_flag) && $stable(vis_tri));

  assert_input_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vis_valid |-> !pix_ready);

  assert_clear_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_busy |-> !pix_ready && !s1_v);

  assert_write_follows_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    zmem_wr_en && !clear_busy |-> $past(zmem_rd_en) && $past(zmem_rd_addr) == zmem_wr_addr);

  assert_result_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vis_valid) |-> $past(s1_v && s1_last));
endmodule

// File: tb/idx_depth_test_test.sv
module idx_depth_test_test;
  localparam int W = 4, H = 3, ZW = 4, TW = 4, NP = W * H, AW = $clog2(NP);
  localparam logic [ZW-1:0] ZMAX = {ZW{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic pix_valid = 0, pix_last = 0, clear_req = 0, vis_ready = 0;
  logic [$clog2(W)-1:0] pix_x = '0;
  logic [$clog2(H)-1:0] pix_y = '0;
  logic [ZW-1:0] pix_z = '0;
  logic [TW-1:0] pix_tri = '0;
  logic pix_ready, clear_busy, vis_valid, vis_flag;
  logic [TW-1:0] vis_tri;
  logic zmem_rd_en, zmem_wr_en, imem_wr_en;
  logic [AW-1:0] zmem_rd_addr, zmem_wr_addr, imem_wr_addr;
  logic [ZW-1:0] zmem_rd_data, zmem_wr_data;
  logic [TW-1:0] imem_wr_data;

  idx_depth_test #(.SCR_W(W), .SCR_H(H), .ZW(ZW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_x(pix_x), .pix_y(pix_y), .pix_z(pix_z), .pix_tri(pix_tri), .pix_last(pix_last),
    .clear_req(clear_req), .clear_busy(clear_busy), .vis_valid(vis_valid),
    .vis_ready(vis_ready), .vis_flag(vis_flag), .vis_tri(vis_tri),
    .zmem_rd_en(zmem_rd_en), .zmem_rd_addr(zmem_rd_addr), .zmem_rd_data(zmem_rd_data),
    .zmem_wr_en(zmem_wr_en), .zmem_wr_addr(zmem_wr_addr), .zmem_wr_data(zmem_wr_data),
    .imem_wr_en(imem_wr_en), .imem_wr_addr(imem_wr_addr), .imem_wr_data(imem_wr_data));

  logic [ZW-1:0] zmem [NP];
  logic [TW-1:0] imem [NP];
  always @(posedge clk) begin
    if (zmem_rd_en) zmem_rd_data <= zmem[zmem_rd_addr];
    if (zmem_wr_en) zmem[zmem_wr_addr] <= zmem_wr_data;
    if (imem_wr_en) imem[imem_wr_addr] <= imem_wr_data;
  end

  logic [ZW-1:0] ref_z [NP];
  logic [TW-1:0] ref_i [NP];
  logic ref_any = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int x, input int y, input int z, input int t, input bit last);
    int a;
    a = y * W + x;
    pix_valid = 1; pix_x = x[$clog2(W)-1:0]; pix_y = y[$clog2(H)-1:0];
    pix_z = z[ZW-1:0]; pix_tri = t[TW-1:0]; pix_last = last;
    if (z[ZW-1:0] < ref_z[a]) begin
      ref_z[a] = z[ZW-1:0]; ref_i[a] = t[TW-1:0]; ref_any = 1;
    end
    while (!pix_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_tri(input int t, input int hold, input string req);
    int g;
    bit exp;
    exp = ref_any;
    ref_any = 0;
    pix_valid = 0; pix_last = 0;
    g = 0;
    while (!vis_valid && g < 50) begin g++; @(negedge clk); end
    chk(vis_valid, "R5 vis_valid", vis_valid, 1);
    chk(vis_flag == exp, req, vis_flag, exp);
    chk(vis_tri == t[TW-1:0], "R5 vis_tri", vis_tri, t);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(vis_valid && vis_flag == exp && vis_tri == t[TW-1:0], "R6 result held", vis_valid, 1);
      chk(!pix_ready, "R6 input closed", pix_ready, 0);
    end
    vis_ready = 1;
    @(negedge clk);
    vis_ready = 0;
    chk(!vis_valid && pix_ready, "R6 released after handshake", vis_valid, 0);
  endtask

  task automatic cmp_mem(input string req);
    int bad;
    bad = 0;
    for (int a = 0; a < NP; a++)
      if (zmem[a] !== ref_z[a] || imem[a] !== ref_i[a]) begin
        if (bad == 0) $display("  mismatch at %0d: z=%0d/%0d idx=%0d/%0d",
                               a, zmem[a], ref_z[a], imem[a], ref_i[a]);
        bad++;
      end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic do_clear();
    int cnt;
    bit seen;
    clear_req = 1;
    @(negedge clk);
    clear_req = 0;
    cnt = 0; seen = 0;
    while (!pix_ready && cnt < 1000) begin
      cnt++;
      if (clear_busy) seen = 1;
      @(negedge clk);
    end
    chk(cnt >= NP, "R7 input stalled for sweep", cnt, NP);
    chk(seen, "R7 clear_busy seen", seen, 1);
    for (int a = 0; a < NP; a++) begin ref_z[a] = ZMAX; ref_i[a] = '0; end
    cmp_mem("R7 stores cleared");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!zmem_wr_en && !imem_wr_en, "R8 no writes in reset", zmem_wr_en, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pix_ready, "R8 pix_ready", pix_ready, 1);
    chk(!vis_valid, "R8 vis_valid", vis_valid, 0);
    chk(!clear_busy, "R8 clear_busy", clear_busy, 0);
    chk(!zmem_wr_en && !imem_wr_en, "R8 no writes", zmem_wr_en, 0);

    do_clear();

    // R1 R3: every address written with z = a+2 by triangle 1
    for (int a = 0; a < NP; a++) send(a % W, a / W, a + 2, 1, a == NP - 1);
    finish_tri(1, 3, "R5 visible triangle");
    cmp_mem("R1 R3 addressed writes");

    // R2: fully behind
    for (int a = 0; a < NP; a++) send(a % W, a / W, 15, 2, a == NP - 1);
    finish_tri(2, 0, "R5 hidden triangle");
    cmp_mem("R2 greater depth ignored");

    // R2: equal depth fails
    for (int a = 0; a < NP; a++) send(a % W, a / W, a + 2, 3, a == NP - 1);
    finish_tri(3, 0, "R2 ties invisible");
    cmp_mem("R2 equal depth ignored");

    // R4: address 5 holds 7; 4 then 6 back to back
    send(1, 1, 4, 4, 0);
    send(1, 1, 6, 5, 1);
    finish_tri(5, 1, "R4 visible via first pixel");
    cmp_mem("R4 forwarded depth");

    // near-exhaustive sweep, with doubled same-address pixels
    for (int t = 6; t < 16; t++) begin
      for (int a = 0; a < NP; a++) begin
        send(a % W, a / W, (a * 3 + t * 7) % 16, t, 0);
        send(a % W, a / W, (a * 5 + t * 3) % 16, t, a == NP - 1);
      end
      finish_tri(t, t % 3, "R5 sweep visibility");
      cmp_mem("R4 R2 sweep contents");
    end

    do_clear();
    send(3, 2, 0, 9, 1);
    finish_tri(9, 0, "R5 single pixel");
    cmp_mem("R3 single write after clear");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule